// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

A bank of 32-bit control registers on a simple synchronous bus. Each register occupies a 16-byte window of the byte address space. Each of the four word addresses in that window reaches the same stored word. The word address inside the window selects how a write changes the word: plain replace, bitwise OR, bitwise AND-NOT, or bitwise XOR. Software can therefore change single control bits with one bus write and needs no read-modify-write sequence.

Reads return the stored word through a registered read port, whichever of the four addresses is used. The block reports an access as illegal when it is misaligned or names a slot beyond the bank depth. An illegal access changes nothing, and the error output pulses for one cycle. The depth and the address width are parameters. The asynchronous active-low reset is released through a two-stage synchronizer, and every register in the bank clears to zero on reset.

Top module: `alias_reg_bank`

## Requirements
- R1: After reset every register reads as zero, and both `rdata` and `err` are zero.
- R2: A write at window offset 0x0 (addr[3:2]=00) replaces the register with `wdata`. The register index is addr[ADDR_W-1:4].
- R3: A write at window offset 0x4 (addr[3:2]=01) ORs `wdata` into the register.
- R4: A write at window offset 0x8 (addr[3:2]=10) clears every register bit that is 1 in `wdata`.
- R5: A write at window offset 0xC (addr[3:2]=11) XORs `wdata` into the register.
- R6: A read at any of the four offsets of a window returns that window's single stored value.
- R7: `rdata` is registered: it is valid in the cycle after `rd_en`, and it holds its value while `rd_en` is low.
- R8: A write and a read to the same register in the same cycle return the value from before the write. A read in the next cycle returns the updated value.
- R9: An access with addr[1:0] not equal to 00 changes no register, loads zero into `rdata` if it is a read, and raises `err` for one cycle.
- R10: An access whose index is N_REGS or more writes nothing, reads as zero, and raises `err` for one cycle.
- R11: A set, clear or toggle write with `wdata` equal to zero leaves the register unchanged and raises no error.
- R12: `err` is low in the cycle after a legal access and in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle illegal-access pulse |

## Verification
The bit operations are driven with data whose patterns overlap the stored value only in part. This shows OR apart from replace, AND-NOT apart from plain AND, and XOR apart from both. Every operation is read back through all four offsets of one window, and also at the first and last slots of the bank. This catches a slot decode that drops or shifts address bits. Zero-valued set, clear and toggle writes separate a correct operation from one that treats the data as a mask to replace with. Misaligned and out-of-range accesses are each followed by a read of the slot they would alias onto. A truncated index would corrupt that slot, and the read shows it.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } alias_op_e;
endpackage

// File: rtl/alias_rst_sync.sv
module alias_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/alias_decode.sv
module alias_decode
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_REGS = 64,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int SLOT_W = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output alias_op_e         op,
  output logic              aligned,
  output logic              in_range
);
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(N_REGS);

  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot     = addr[ADDR_W-1:4];
    idx      = slot[IDX_W-1:0];
    op       = alias_op_e'(addr[3:2]);
    aligned  = (addr[1:0] == 2'b00);
    in_range = ({1'b0, slot} < LIMIT);
  end
endmodule

// File: rtl/alias_update.sv
module alias_update
  import alias_bank_pkg::*;
(
  input  alias_op_e          op,
  input  logic [DATA_W-1:0]  cur,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  nxt
);
  always_comb begin
    unique case (op)
      OP_WRITE:  nxt = wdata;
      OP_SET:    nxt = cur | wdata;
      OP_CLEAR:  nxt = cur & ~wdata;
      OP_TOGGLE: nxt = cur ^ wdata;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/alias_store.sv
module alias_store
  import alias_bank_pkg::*;
#(
  parameter int N_REGS = 64,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ok,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [DATA_W-1:0]        rd_word
);
  logic [DATA_W-1:0] word_q [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_word
    logic              word_en;
    logic [DATA_W-1:0] word_d;

    always_comb begin
      word_en = wr_ok && (wr_idx == IDX_W'(i));
      word_d  = word_en ? wr_data : word_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= '0;
      else        word_q[i] <= word_d;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < N_REGS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_word = word_q[k];
    end
  end
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_REGS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx;
  alias_op_e         op;
  logic              aligned;
  logic              in_range;
  logic              legal;
  logic              wr_ok;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] new_word;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  alias_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alias_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_decode (
    .addr     (addr),
    .idx      (idx),
    .op       (op),
    .aligned  (aligned),
    .in_range (in_range)
  );

  alias_update u_update (
    .op    (op),
    .cur   (cur_word),
    .wdata (wdata),
    .nxt   (new_word)
  );

  alias_store #(.N_REGS(N_REGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ok   (wr_ok),
    .wr_idx  (idx),
    .wr_data (new_word),
    .rd_idx  (idx),
    .rd_word (cur_word)
  );

  always_comb begin
    legal   = aligned && in_range;
    wr_ok   = wr_en && legal;
    rdata_d = rdata_q;
    if (rd_en) rdata_d = legal ? cur_word : '0;
    err_d   = (wr_en || rd_en) && !legal;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/alias_reg_bank_chk.sv
module alias_reg_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int N_REGS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              err
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(N_REGS);

  logic access, oor, misal;
  always_comb begin
    access = wr_en || rd_en;
    oor    = !({1'b0, addr[ADDR_W-1:4]} < LIMIT);
    misal  = (addr[1:0] != 2'b00);
  end

  assert_err_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    access && misal |=> err);

  assert_err_out_of_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    access && oor |=> err);

  assert_oor_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && oor |=> (rdata == 32'h0));

  assert_no_err_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    access && !misal && !oor |=> !err);

  assert_no_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !err);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

bind alias_reg_bank alias_reg_bank_chk #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .addr  (addr),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .wdata (wdata),
  .rdata (rdata),
  .err   (err)
);

// File: tb/alias_reg_bank_test.sv
module alias_reg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        er;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mdl [64];
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  alias_reg_bank #(.ADDR_W(12), .N_REGS(64)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic we, input logic re,
                        input logic [31:0] d, input string tag);
    logic [7:0] slot;
    logic       legal;
    exp_t       e;
    @(negedge clk);
    addr = a; wr_en = we; rd_en = re; wdata = d;
    slot  = a[11:4];
    legal = (a[1:0] == 2'b00) && (slot < 8'd64);
    e.er  = (we || re) && !legal;
    if (re) last_rd = legal ? mdl[slot[5:0]] : 32'h0;
    e.rd  = last_rd;
    e.tag = tag;
    q.push_back(e);
    if (we && legal) begin
      case (a[3:2])
        2'b00: mdl[slot[5:0]] = d;
        2'b01: mdl[slot[5:0]] = mdl[slot[5:0]] | d;
        2'b10: mdl[slot[5:0]] = mdl[slot[5:0]] & ~d;
        default: mdl[slot[5:0]] = mdl[slot[5:0]] ^ d;
      endcase
    end
  endtask

  task automatic idle(input string tag);
    access(12'h000, 1'b0, 1'b0, 32'h0, tag);
  endtask

  // Monitor: compares each cycle's result against the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(rdata, e.rd, {e.tag, " rdata"});
        check({31'h0, err}, {31'h0, e.er}, {e.tag, " err"});
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(rdata, 32'h0, "R1 rdata after reset");
    check({31'h0, err}, 32'h0, "R1 err after reset");
    access(12'h000, 0, 1, 0, "R1 read slot0");
    access(12'h050, 0, 1, 0, "R1 read slot5");
    access(12'h3F0, 0, 1, 0, "R1 read slot63");
    // R2 replace, R6 all aliases
    access(12'h030, 1, 0, 32'hA5A5_0F0F, "R2 write slot3");
    access(12'h030, 0, 1, 0, "R2 readback");
    access(12'h034, 0, 1, 0, "R6 alias 4");
    access(12'h038, 0, 1, 0, "R6 alias 8");
    access(12'h03C, 0, 1, 0, "R6 alias C");
    // R3 set
    access(12'h034, 1, 0, 32'h0000_F0F0, "R3 set");
    access(12'h030, 0, 1, 0, "R3 readback");
    // R4 clear
    access(12'h038, 1, 0, 32'hA000_0003, "R4 clear");
    access(12'h03C, 0, 1, 0, "R4 readback");
    // R5 toggle
    access(12'h03C, 1, 0, 32'hFFFF_0000, "R5 toggle");
    access(12'h034, 0, 1, 0, "R5 readback");
    // R11 zero-data bit operations
    access(12'h034, 1, 0, 32'h0, "R11 set zero");
    access(12'h038, 1, 0, 32'h0, "R11 clear zero");
    access(12'h03C, 1, 0, 32'h0, "R11 toggle zero");
    access(12'h030, 0, 1, 0, "R11 readback");
    // R2 at bank edges
    access(12'h3F0, 1, 0, 32'h1234_5678, "R2 write slot63");
    access(12'h000, 1, 0, 32'hCAFE_0001, "R2 write slot0");
    access(12'h3F8, 0, 1, 0, "R2 read slot63");
    access(12'h004, 0, 1, 0, "R2 read slot0");
    // R8 same-cycle write and read
    access(12'h3FC, 1, 1, 32'h0000_FFFF, "R8 toggle+read old");
    access(12'h3F0, 0, 1, 0, "R8 read new");
    access(12'h034, 1, 1, 32'h8000_0000, "R8 set+read old");
    access(12'h030, 0, 1, 0, "R8 set read new");
    // R7 hold without rd_en
    idle("R7 hold 1");
    access(12'h030, 1, 0, 32'h0BAD_BEEF, "R7 write no read");
    idle("R7 hold 2");
    access(12'h030, 0, 1, 0, "R7 read");
    // R9 misaligned
    access(12'h031, 1, 0, 32'hFFFF_FFFF, "R9 misaligned write");
    idle("R9 err one cycle");
    access(12'h030, 0, 1, 0, "R9 slot3 unchanged");
    access(12'h032, 0, 1, 0, "R9 misaligned read");
    access(12'h037, 1, 0, 32'hFFFF_FFFF, "R9 misaligned set");
    access(12'h030, 0, 1, 0, "R9 slot3 unchanged 2");
    // R10 out of range
    access(12'h400, 1, 0, 32'hDEAD_0000, "R10 oor write");
    access(12'h000, 0, 1, 0, "R10 slot0 unchanged");
    access(12'h43C, 1, 0, 32'hFFFF_FFFF, "R10 oor toggle");
    access(12'h3F0, 0, 1, 0, "R10 read slot63");
    access(12'h400, 0, 1, 0, "R10 oor read");
    access(12'h830, 0, 1, 0, "R10 oor read high");
    access(12'h030, 0, 1, 0, "R10 slot3 unchanged");
    // R12 legal and idle
    access(12'h100, 1, 0, 32'h0000_0001, "R12 legal write");
    idle("R12 idle");
    access(12'h108, 0, 1, 0, "R12 legal read");
    idle("R12 idle end");
    idle("R12 idle end 2");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule